// File: doc/BRIEF.md
# Multi-Level Cell Program-Verify Step Sequencer

This block drives the write of a small group of multi-level flash cells by the incremental step method. Each cell holds two bits as one of four threshold levels. On a start strobe the sequencer captures the 2-bit target of every cell, a start voltage code, a small step size, a multiplier for the large step, and a step-size select. It then repeats an iteration: one program pulse at the current voltage code, a fixed settle interval, and a verify strobe. During the verify strobe it samples a per-cell comparator that reports whether the cell's threshold lies above the verify level of its own target.

A cell that verifies is inhibited and gets no more pulses. The voltage code rises by the chosen step after each iteration. The operation ends when every cell is inhibited, or it ends with a failure when the pulse budget runs out first. The large step reaches the targets in fewer pulses. The small step leaves each cell's final threshold no more than one small step above its verify level. The analog cell array sits outside the block, on the voltage, pulse, inhibit and verify-level outputs.

Top module: `mlc_pv_seq`

## Requirements
- R1: While reset is held and in the first idle cycle after it, `done`, `fail`, `pgm_pulse`, `vfy_strobe` and `pulse_cnt` are all zero.
- R2: On an accepted start, each cell's 2-bit target in `tgt_data[2i+1:2i]` is mapped to a verify rank on `vfy_level[2i+1:2i]`, in rising threshold order: 11 gives 0, 10 gives 1, 00 gives 2, 01 gives 3. A cell with target 11 is inhibited from the start and receives no pulse. If every target is 11, the operation ends with `done`, no pulses and `pulse_cnt` 0.
- R3: Pulse n (n counted from 1) is driven with `vpgm_code` equal to start_code + (n-1) x step, saturating at the all-ones code.
- R4: With `large_step`=0 the step is `step_small`. With `large_step`=1 it is `step_small` x `step_mult`. With the small step, a cell that needed more than one pulse finishes with its threshold at most one small step above its verify level.
- R5: `pgm_pulse` is high for exactly one cycle. `vfy_strobe` follows after exactly SETTLE cycles, stays high for one cycle, and `cell_above` is sampled only in that cycle.
- R6: A cell whose comparator reads 1 during a verify strobe is inhibited (`pgm_inhibit[i]`=1) and stays inhibited until the next start. So each cell receives exactly the number of pulses it needs.
- R7: When every cell is inhibited, `done` pulses for one cycle with `fail`=0. `pulse_cnt` equals the number of pulses applied and holds until the next start.
- R8: If any cell is still uninhibited after MAX_PULSES pulses, the operation ends with `done` and `fail`=1. `pulse_cnt` then equals MAX_PULSES, and `fail` holds until the next start.
- R9: A start asserted while an operation is in progress is ignored. The targets, step and result of the running operation are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| tgt_data | input | 2*NCELL | 2-bit target per cell |
| large_step | input | 1 | 1 selects the large step |
| start_code | input | VW | Voltage code of the first pulse |
| step_small | input | VW | Small step increment |
| step_mult | input | MW | Large step = small step times this factor |
| cell_above | input | NCELL | Per-cell comparator: threshold above verify level |
| vpgm_code | output | VW | Program voltage code |
| pgm_pulse | output | 1 | Program pulse strobe |
| pgm_inhibit | output | NCELL | Per-cell inhibit (1 = no pulse) |
| vfy_strobe | output | 1 | Verify strobe |
| vfy_level | output | 2*NCELL | Verify rank per cell |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Pulse budget exhausted |
| pulse_cnt | output | clog2(MAX_PULSES+1) | Pulses applied in the last operation |

## Verification
The bench runs every one of the 256 target combinations of four cells with each step size. It models each cell as a threshold that follows the pulse voltage minus a per-cell offset, and works out arithmetically how many pulses each cell needs. A design with a wrong level order or a wrong inhibit would over-pulse or under-pulse particular cells, and a design that ignored target 11 would pulse erased cells. The budget-exhaustion and saturation cases catch a design that hangs, reports the wrong count, or wraps the voltage code to a low value. A start during a running operation catches a design that reloads its targets partway through.

// File: rtl/mlc_pv_pkg.sv
package mlc_pv_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_PULSE,
    S_SETTLE,
    S_VERIFY,
    S_UPDATE
  } seq_state_t;

  // Rising-threshold rank of a 2-bit target: 11 -> 0, 10 -> 1, 00 -> 2, 01 -> 3
  function automatic logic [1:0] data_to_rank(input logic [1:0] d);
    case (d)
      2'b11:   data_to_rank = 2'd0;
      2'b10:   data_to_rank = 2'd1;
      2'b00:   data_to_rank = 2'd2;
      default: data_to_rank = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/mlc_rank_map.sv
module mlc_rank_map #(
  parameter int NCELL = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [2*NCELL-1:0] tgt,
  output logic [2*NCELL-1:0] rank,
  output logic [NCELL-1:0]   erased_now
);
  import mlc_pv_pkg::*;

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    assign erased_now[i] = (tgt[2*i+1:2*i] == 2'b11);

    always_ff @(posedge clk) begin
      if (rst)
        rank[2*i+1:2*i] <= 2'd0;
      else if (load)
        rank[2*i+1:2*i] <= data_to_rank(tgt[2*i+1:2*i]);
    end
  end

  // R9: the ranks change only on a load
  p_rank_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(rank));

endmodule

// File: rtl/mlc_step_gen.sv
module mlc_step_gen #(
  parameter int VW = 8,
  parameter int MW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          advance,
  input  logic          large_sel,
  input  logic [VW-1:0] start_code,
  input  logic [VW-1:0] step_small,
  input  logic [MW-1:0] step_mult,
  output logic [VW-1:0] vpgm_code
);
  localparam int PW = VW + MW;
  localparam logic [VW-1:0] VMAX = {VW{1'b1}};

  logic [VW-1:0] step_q;
  logic [PW-1:0] prod;
  logic [VW-1:0] step_sel;
  logic [VW:0]   sum;

  assign prod     = PW'(step_small) * PW'(step_mult);
  assign step_sel = !large_sel ? step_small :
                    (prod > PW'(VMAX)) ? VMAX : prod[VW-1:0];
  assign sum      = {1'b0, vpgm_code} + {1'b0, step_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q    <= '0;
      vpgm_code <= '0;
    end else if (load) begin
      step_q    <= step_sel;
      vpgm_code <= start_code;
    end else if (advance) begin
      vpgm_code <= sum[VW] ? VMAX : sum[VW-1:0];
    end
  end

  // R3: the code never wraps downward when it advances
  p_code_rises_r3: assert property (@(posedge clk) disable iff (rst)
    (advance && !load) |=> vpgm_code >= $past(vpgm_code));

  // R4: the step stays constant through an operation
  p_step_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(step_q));

endmodule

// File: rtl/mlc_inhibit_bank.sv
module mlc_inhibit_bank #(
  parameter int NCELL = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [NCELL-1:0] load_mask,
  input  logic             sample,
  input  logic [NCELL-1:0] above,
  output logic [NCELL-1:0] inhibit,
  output logic             all_inh
);

  for (genvar i = 0; i < NCELL; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        inhibit[i] <= 1'b0;
      else if (load)
        inhibit[i] <= load_mask[i];
      else if (sample && above[i])
        inhibit[i] <= 1'b1;
    end
  end

  assign all_inh = &inhibit;

  // R6: an inhibited cell stays inhibited until the next load
  p_inhibit_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    !load |=> ((inhibit & $past(inhibit)) == $past(inhibit)));

  // R5: the comparator affects nothing outside a verify sample
  p_no_sample_r5: assert property (@(posedge clk) disable iff (rst)
    (!load && !sample) |=> $stable(inhibit));

  // R2: erased targets start inhibited
  p_erased_start_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> ((inhibit & $past(load_mask)) == $past(load_mask)));

endmodule

// File: rtl/mlc_pv_seq.sv
module mlc_pv_seq #(
  parameter int NCELL      = 4,
  parameter int VW         = 8,
  parameter int MW         = 3,
  parameter int MAX_PULSES = 32,
  parameter int SETTLE     = 3
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               start,
  input  logic [2*NCELL-1:0]                 tgt_data,
  input  logic                               large_step,
  input  logic [VW-1:0]                      start_code,
  input  logic [VW-1:0]                      step_small,
  input  logic [MW-1:0]                      step_mult,
  input  logic [NCELL-1:0]                   cell_above,
  output logic [VW-1:0]                      vpgm_code,
  output logic                               pgm_pulse,
  output logic [NCELL-1:0]                   pgm_inhibit,
  output logic                               vfy_strobe,
  output logic [2*NCELL-1:0]                 vfy_level,
  output logic                               done,
  output logic                               fail,
  output logic [$clog2(MAX_PULSES+1)-1:0]    pulse_cnt
);
  import mlc_pv_pkg::*;

  localparam int CNTW = $clog2(MAX_PULSES + 1);
  localparam int SW   = (SETTLE > 1) ? $clog2(SETTLE) : 1;

  seq_state_t       state, nxt;
  logic [SW-1:0]    set_cnt;
  logic             load;
  logic             advance;
  logic             all_inh;
  logic             at_limit;
  logic [NCELL-1:0] erased_now;

  assign load     = (state == S_IDLE) && start;
  assign at_limit = (pulse_cnt == CNTW'(MAX_PULSES));
  assign advance  = (state == S_UPDATE) && (nxt == S_PULSE);

  mlc_rank_map #(.NCELL(NCELL)) u_rank (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .tgt        (tgt_data),
    .rank       (vfy_level),
    .erased_now (erased_now)
  );

  mlc_step_gen #(.VW(VW), .MW(MW)) u_step (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .advance    (advance),
    .large_sel  (large_step),
    .start_code (start_code),
    .step_small (step_small),
    .step_mult  (step_mult),
    .vpgm_code  (vpgm_code)
  );

  mlc_inhibit_bank #(.NCELL(NCELL)) u_inh (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_mask (erased_now),
    .sample    (state == S_VERIFY),
    .above     (cell_above),
    .inhibit   (pgm_inhibit),
    .all_inh   (all_inh)
  );

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:   if (start) nxt = S_LOAD;
      S_LOAD:   nxt = all_inh ? S_IDLE : S_PULSE;
      S_PULSE:  nxt = S_SETTLE;
      S_SETTLE: if (set_cnt == SW'(SETTLE - 1)) nxt = S_VERIFY;
      S_VERIFY: nxt = S_UPDATE;
      S_UPDATE: nxt = (all_inh || at_limit) ? S_IDLE : S_PULSE;
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      set_cnt    <= '0;
      pgm_pulse  <= 1'b0;
      vfy_strobe <= 1'b0;
      done       <= 1'b0;
      fail       <= 1'b0;
      pulse_cnt  <= '0;
    end else begin
      state      <= nxt;
      pgm_pulse  <= (nxt == S_PULSE);
      vfy_strobe <= (nxt == S_VERIFY);
      done       <= ((state == S_LOAD) || (state == S_UPDATE)) && (nxt == S_IDLE);
      if (state == S_SETTLE)
        set_cnt <= set_cnt + SW'(1);
      else
        set_cnt <= '0;
      if (load) begin
        pulse_cnt <= '0;
        fail      <= 1'b0;
      end else begin
        if (nxt == S_PULSE)
          pulse_cnt <= pulse_cnt + CNTW'(1);
        if ((state == S_UPDATE) && !all_inh && at_limit)
          fail <= 1'b1;
      end
    end
  end

  // R7: done is a single-cycle pulse
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: fail only rises together with done
  p_fail_with_done_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> done);

  // R8: the pulse count never exceeds its budget
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    pulse_cnt <= CNTW'(MAX_PULSES));

  // R5: the pulse lasts one cycle and the verify strobe follows settling
  p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
    pgm_pulse |=> !pgm_pulse);
  p_verify_after_settle_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(vfy_strobe) |-> ($past(state) == S_SETTLE));

  // R7: the result holds while idle
  p_cnt_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !start) |=> $stable(pulse_cnt) && $stable(fail));

endmodule

// File: tb/mlc_pv_seq_tb.sv
module mlc_pv_seq_tb;
  localparam int NC     = 4;
  localparam int VW     = 8;
  localparam int MW     = 3;
  localparam int MAXP   = 32;
  localparam int SETTLE = 3;
  localparam int CNTW   = $clog2(MAXP + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [2*NC-1:0] tgt_data = '0;
  logic large_step = 1'b0;
  logic [VW-1:0] start_code = '0, step_small = '0;
  logic [MW-1:0] step_mult = '0;
  logic [NC-1:0] cell_above;
  logic [VW-1:0] vpgm_code;
  logic pgm_pulse, vfy_strobe, done, fail;
  logic [NC-1:0] pgm_inhibit;
  logic [2*NC-1:0] vfy_level;
  logic [CNTW-1:0] pulse_cnt;

  always #5 clk = ~clk;

  mlc_pv_seq #(.NCELL(NC), .VW(VW), .MW(MW), .MAX_PULSES(MAXP), .SETTLE(SETTLE)) u_dut (
    .clk(clk), .rst(rst), .start(start), .tgt_data(tgt_data), .large_step(large_step),
    .start_code(start_code), .step_small(step_small), .step_mult(step_mult),
    .cell_above(cell_above), .vpgm_code(vpgm_code), .pgm_pulse(pgm_pulse),
    .pgm_inhibit(pgm_inhibit), .vfy_strobe(vfy_strobe), .vfy_level(vfy_level),
    .done(done), .fail(fail), .pulse_cnt(pulse_cnt)
  );

  int n_checks = 0, n_fail = 0;
  int vth[NC], koff[NC], rk[NC], cell_p[NC];
  int pulse_seen, gap, cur_start, cur_step;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rank_of(input logic [1:0] d);
    case (d) 2'b11: return 0; 2'b10: return 1; 2'b00: return 2; default: return 3; endcase
  endfunction

  function automatic int vl(input int r); return 40 * r; endfunction

  function automatic int vexp(input int n);
    int v = cur_start + (n - 1) * cur_step;
    return (v > 255) ? 255 : v;
  endfunction

  function automatic int need(input int c);
    if (rk[c] == 0) return 0;
    for (int n = 1; n <= MAXP; n++)
      if (vexp(n) - koff[c] > vl(rk[c])) return n;
    return MAXP + 1;
  endfunction

  // cell model: threshold follows pulse voltage less a per-cell offset
  always_comb
    for (int i = 0; i < NC; i++) cell_above[i] = (vth[i] > vl(rk[i]));

  always @(negedge clk) begin
    if (pgm_pulse) begin
      pulse_seen++;
      chk(vpgm_code == VW'(vexp(pulse_seen)), "R3 pulse voltage", vpgm_code, vexp(pulse_seen));
      for (int i = 0; i < NC; i++)
        if (!pgm_inhibit[i]) begin
          cell_p[i]++;
          if (int'(vpgm_code) - koff[i] > vth[i]) vth[i] = int'(vpgm_code) - koff[i];
        end
      gap = 0;
    end else begin
      gap++;
      if (vfy_strobe) chk(gap == SETTLE + 1, "R5 settle gap", gap, SETTLE + 1);
    end
  end

  task automatic begin_op(input logic [2*NC-1:0] t, input bit lg, input int s0, input int ss, input int mu);
    @(negedge clk);
    for (int i = 0; i < NC; i++) begin
      vth[i] = 0; cell_p[i] = 0; rk[i] = rank_of(t[2*i+1 -: 2]);
    end
    pulse_seen = 0; gap = 0;
    cur_start = s0; cur_step = lg ? ss * mu : ss;
    tgt_data = t; large_step = lg; start_code = VW'(s0); step_small = VW'(ss); step_mult = MW'(mu);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_op(input bit small_chk);
    int mx = 0, e, lv = 0;
    while (!done) @(negedge clk);
    for (int i = 0; i < NC; i++) begin
      e = need(i);
      if (e > mx) mx = e;
      lv = lv | (rk[i] << (2 * i));
      chk(cell_p[i] == ((e > MAXP) ? MAXP : e), "R6 per-cell pulses", cell_p[i], e);
      if (rk[i] == 0) chk(cell_p[i] == 0, "R2 erased cell untouched", cell_p[i], 0);
      if (small_chk && e > 1 && e <= MAXP)
        chk(vth[i] <= vl(rk[i]) + cur_step, "R4 tight spread", vth[i], vl(rk[i]) + cur_step);
    end
    chk(vfy_level == (2*NC)'(lv), "R2 verify ranks", vfy_level, lv);
    chk(fail == (mx > MAXP), "R8 fail flag", fail, mx > MAXP);
    chk(pulse_cnt == CNTW'((mx > MAXP) ? MAXP : mx), "R7 pulse count", pulse_cnt, mx);
    @(negedge clk);
    chk(!done, "R7 done one cycle", done, 0);
    repeat (3) @(negedge clk);
    chk(pulse_cnt == CNTW'((mx > MAXP) ? MAXP : mx), "R7 count held", pulse_cnt, mx);
  endtask

  task automatic run_all();
    for (int i = 0; i < NC; i++) begin vth[i] = 0; rk[i] = 0; koff[i] = 0; cell_p[i] = 0; end
    koff[0] = 0; koff[1] = 5; koff[2] = 10; koff[3] = 3;
    repeat (3) @(negedge clk);
    chk(!done && !fail && !pgm_pulse && !vfy_strobe && pulse_cnt == 0, "R1 reset outputs", done, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !fail && !pgm_pulse && !vfy_strobe && pulse_cnt == 0, "R1 idle after reset", pulse_cnt, 0);
    // R4 small step sweep over all targets
    for (int t = 0; t < 256; t++) begin begin_op(8'(t), 1'b0, 30, 4, 3); finish_op(1'b1); end
    // R4 large step sweep over all targets
    for (int t = 0; t < 256; t++) begin begin_op(8'(t), 1'b1, 30, 4, 3); finish_op(1'b0); end
    // R8 budget exhausted: start at zero with small step
    begin_op(8'h55, 1'b0, 0, 4, 3); finish_op(1'b0);
    chk(fail == 1'b1, "R8 fail case", fail, 1);
    // R3 saturation: cells that never pass while the code climbs to the top
    for (int i = 0; i < NC; i++) koff[i] = 200;
    begin_op(8'h55, 1'b1, 240, 4, 3); finish_op(1'b0);
    koff[0] = 0; koff[1] = 5; koff[2] = 10; koff[3] = 3;
    // R9 start while busy is ignored
    begin_op(8'h55, 1'b0, 30, 4, 3);
    repeat (20) @(negedge clk);
    tgt_data = 8'hAA; large_step = 1'b1; start_code = 8'd200; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(vfy_level == 8'hFF, "R9 ranks kept", vfy_level, 8'hFF);
    finish_op(1'b1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule